// File: doc/BRIEF.md
# Addressed serial display-data receiver

This block is a receive-only serial slave that loads a frame of segment bits for a display driver. It listens to a bus clock line and a bus data line, both idling high. An optional enable line controls when a received frame is shown. A bus master opens a session with a start condition and sends an 8-bit device address, most significant bit first. If the address equals the block's configured address, the block shifts in the data bits that follow and copies each complete frame into a parallel display register.

The display register is updated in one of two ways. With the enable line held high, an internal bit counter copies the frame after its last bit. With the enable line held low, the counter copy is suppressed, and a rising edge on the enable line while the bus clock is high performs the copy instead. A session may stay open across frames. One spare clock edge separates consecutive frames, and a stop condition ends the session at any point without touching the display. The block never drives the bus. All bus inputs are synchronised to the system clock before use.

Top module: `serial_seg_rx`

## Requirements
- R1: After reset the display output `disp` is all zeros.
- R2: A start condition is a falling edge of the data line while the bus clock stays high. It opens an address phase and clears the bit counter from any state.
- R3: The eight bits after a start are an address, sent most significant bit first and compared with `dev_addr`. On a mismatch every bit up to the next start is ignored and `disp` keeps its value.
- R4: In an addressed session one data bit is sampled on each rising bus clock edge and shifted in MSB-first, so the first data bit of a frame ends up in `disp[127]` and the last in `disp[0]`.
- R5: While `bus_en` is high, the shift contents are copied to `disp` as soon as the 128th data bit of a frame has been received.
- R6: While `bus_en` is low, completing a frame leaves `disp` unchanged. A rising edge of `bus_en` while the bus clock is high copies the shift contents to `disp`.
- R7: A rising edge of `bus_en` while the bus clock is low leaves `disp` unchanged.
- R8: With no start or stop after a frame, the next rising bus clock edge (the 129th) is skipped, and the next frame's first bit is taken on the edge after it (the 130th).
- R9: A stop condition is a rising edge of the data line while the bus clock stays high. It returns the block to idle without copying a partial frame, and only a new start plus a matching address resumes reception.
- R10: A start during a frame discards the partial frame. The next frame is counted from its own first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | 8 | Configured device address |
| bus_clk | input | 1 | Serial bus clock, idles high |
| bus_dat | input | 1 | Serial bus data, idles high |
| bus_en | input | 1 | Display-copy enable |
| disp | output | 128 | Parallel display register |

## Verification
A bus edge reaches `disp` on the third system clock edge after it: two synchroniser flops, then the register that compares current and previous samples updates the state and the display. The bench holds every bus level for eight system clocks and reads `disp` at a falling clock edge after that hold, so each result has settled and no next bus edge has begun. Enable pulses and skipped edges get the same eight-cycle spacing, and each check of an unchanged `disp` is taken after the stimulus that could have disturbed it and before any later copy.

// File: rtl/serial_seg_rx.sv
module serial_seg_rx #(
  parameter int FRAME_BITS  = 128,
  parameter int ADDR_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_BITS-1:0]  dev_addr,
  input  logic                  bus_clk,
  input  logic                  bus_dat,
  input  logic                  bus_en,
  output logic [FRAME_BITS-1:0] disp
);

  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] ADDR_LAST  = CW'(ADDR_BITS - 1);
  localparam logic [CW-1:0] FRAME_LAST = CW'(FRAME_BITS - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_SKIP, S_DEAF} st_t;

  logic [SYNC_STAGES-1:0] ck_s, dt_s, en_s;
  logic                   ck_p, dt_p, en_p;
  st_t                    st;
  logic [CW-1:0]          cnt;
  logic [ADDR_BITS-1:0]   ab;
  logic [FRAME_BITS-1:0]  sr;

  wire ck = ck_s[SYNC_STAGES-1];
  wire dt = dt_s[SYNC_STAGES-1];
  wire en = en_s[SYNC_STAGES-1];

  wire rise     = ck & ~ck_p;
  wire start    = ck & ck_p & dt_p & ~dt;
  wire stop     = ck & ck_p & ~dt_p & dt;
  wire en_rise  = en & ~en_p & ck;
  wire take     = rise && st == S_DATA;
  wire last     = take && cnt == FRAME_LAST;
  wire [ADDR_BITS-1:0]  ab_nx = {ab[ADDR_BITS-2:0], dt};
  wire [FRAME_BITS-1:0] sr_nx = {sr[FRAME_BITS-2:0], dt};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_s <= '1; dt_s <= '1; en_s <= '1;
      ck_p <= 1'b1; dt_p <= 1'b1; en_p <= 1'b1;
    end else begin
      ck_s <= {ck_s[SYNC_STAGES-2:0], bus_clk};
      dt_s <= {dt_s[SYNC_STAGES-2:0], bus_dat};
      en_s <= {en_s[SYNC_STAGES-2:0], bus_en};
      ck_p <= ck; dt_p <= dt; en_p <= en;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      ab  <= '0;
    end else if (start) begin
      st  <= S_ADDR;
      cnt <= '0;
    end else if (stop) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (rise) begin
      case (st)
        S_ADDR: begin
          ab <= ab_nx;
          if (cnt == ADDR_LAST) begin
            st  <= (ab_nx == dev_addr) ? S_DATA : S_DEAF;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: begin
          if (last) begin
            st  <= S_SKIP;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_SKIP: begin
          st  <= S_DATA;
          cnt <= '0;
        end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr   <= '0;
      disp <= '0;
    end else begin
      if (take) sr <= sr_nx;
      if (last && en) disp <= sr_nx;
      else if (en_rise) disp <= sr;
    end

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(FRAME_BITS));

  assert_hold_low_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(disp));

  assert_deaf_no_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_DEAF |=> $stable(sr));

  assert_skip_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP && rise) |=> (st == S_DATA && cnt == '0 && $stable(sr)));

  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> st == S_IDLE);

  assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (st == S_ADDR && cnt == '0));

endmodule

// File: tb/sim_serial_seg_rx.sv
module sim_serial_seg_rx;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   dev_addr = 8'hA6;
  logic         bus_clk = 1'b1, bus_dat = 1'b1, bus_en = 1'b1;
  logic [127:0] disp;
  int           checks = 0, fails = 0;
  bit           done = 0;
  logic [127:0] expv;

  always #2.5 clk = ~clk;

  serial_seg_rx u0 (.clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .bus_clk(bus_clk),
                    .bus_dat(bus_dat), .bus_en(bus_en), .disp(disp));

  function automatic logic [127:0] pat(input int n);
    logic [127:0] p;
    for (int i = 0; i < 4; i++)
      p[i*32 +: 32] = 32'(n) * 32'h9E3779B9 + 32'(i) * 32'h7F4A7C15 + 32'h1234;
    return p;
  endfunction

  task automatic hold();
    repeat (8) @(posedge clk);
  endtask

  task automatic chk(input string req, input logic [127:0] exp_v);
    @(negedge clk);
    checks++;
    if (disp !== exp_v) begin
      fails++;
      $display("FAIL %s: disp=%h expected=%h", req, disp, exp_v);
    end
  endtask

  task automatic send_bit(input logic b);
    bus_clk = 1'b0; hold();
    bus_dat = b;    hold();
    bus_clk = 1'b1; hold();
  endtask

  task automatic bus_start();
    bus_clk = 1'b0; hold();
    bus_dat = 1'b1; hold();
    bus_clk = 1'b1; hold();
    bus_dat = 1'b0; hold();
  endtask

  task automatic bus_stop();
    bus_clk = 1'b0; hold();
    bus_dat = 1'b0; hold();
    bus_clk = 1'b1; hold();
    bus_dat = 1'b1; hold();
  endtask

  task automatic send_addr(input logic [7:0] a);
    for (int i = 7; i >= 0; i--) send_bit(a[i]);
  endtask

  task automatic send_bits(input logic [127:0] p, input int n);
    for (int i = 0; i < n; i++) send_bit(p[127-i]);
  endtask

  task automatic en_pulse();
    bus_en = 1'b1; hold();
    bus_en = 1'b0; hold();
  endtask

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    hold();
    chk("R1 reset", '0);

    // R2 R4 R5: addressed frame, enable high
    bus_start(); send_addr(8'hA6); send_bits(pat(1), 128);
    expv = pat(1);
    chk("R5 counter copy", expv);
    bus_stop();

    // R3: wrong address ignored
    bus_start(); send_addr(8'h5A); send_bits(pat(2), 128); bus_stop();
    chk("R3 mismatch ignored", expv);

    // R3 sweep: single-bit address errors, then exact match
    for (int k = 0; k <= 8; k++) begin
      logic [7:0] a;
      a = (k < 8) ? (8'hA6 ^ (8'd1 << k)) : 8'hA6;
      bus_start(); send_addr(a); send_bits(pat(10 + k), 128); bus_stop();
      if (a == dev_addr) expv = pat(10 + k);
      chk("R3 address sweep", expv);
    end

    // R4: first bit lands in disp[127]
    bus_start(); send_addr(8'hA6); send_bits({1'b1, 126'd0, 1'b1}, 128); bus_stop();
    expv = {1'b1, 126'd0, 1'b1};
    chk("R4 bit order", expv);

    // R8: streaming with a skipped edge
    bus_start(); send_addr(8'hA6); send_bits(pat(30), 128);
    expv = pat(30);
    chk("R8 first streamed frame", expv);
    send_bit(1'b1);
    chk("R8 skipped edge no change", expv);
    send_bits(pat(31), 128);
    expv = pat(31);
    chk("R8 second streamed frame", expv);
    bus_stop();

    // R9: stop aborts partial frame
    bus_start(); send_addr(8'hA6); send_bits(pat(40), 60); bus_stop();
    chk("R9 abort no copy", expv);
    send_bits(pat(41), 128);
    chk("R9 bits after stop ignored", expv);
    bus_start(); send_addr(8'hA6); send_bits(pat(42), 128); bus_stop();
    expv = pat(42);
    chk("R9 resume after start", expv);

    // R10: repeated start restarts counter
    bus_start(); send_addr(8'hA6); send_bits(pat(50), 50);
    bus_start(); send_addr(8'hA6); send_bits(pat(51), 78);
    chk("R10 no early copy", expv);
    send_bits(pat(51) << 78, 50);
    expv = pat(51);
    chk("R10 restarted frame", expv);
    bus_stop();

    // R6 R7: enable low
    bus_clk = 1'b0; hold();
    bus_en = 1'b0;  hold();
    bus_clk = 1'b1; hold();
    bus_start(); send_addr(8'hA6); send_bits(pat(60), 128);
    chk("R6 no counter copy when enable low", expv);
    bus_clk = 1'b0; hold();
    en_pulse();
    chk("R7 enable pulse with clock low ignored", expv);
    bus_clk = 1'b1; hold();
    en_pulse();
    expv = pat(60);
    chk("R6 enable pulse copies", expv);
    bus_stop();
    bus_start(); send_addr(8'hA6); send_bits(pat(61), 128); bus_stop();
    chk("R6 second frame held", expv);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule